// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps calendar time as packed decimal digits: two digits each for seconds, minutes, hours, day, month and year, and one digit for the weekday. Software reaches every digit and three control registers through a small 4-bit register bus. Each register index is placed at a byte offset eight times its number. An external one-second strobe advances time. A separate 64 Hz strobe gives the fastest rate of the periodic output.

Software freezes the visible digits with a hold bit. A second that arrives during the hold is kept and applied once the hold drops, and a busy flag shows that it is waiting. Other controls round time to the nearest minute, stop counting, and reset the time. The reset also latches the 12- or 24-hour format. The periodic output fires every 1/64 s, every second, every minute or every hour. It is either a level interrupt, cleared by reading the status register, or a one-cycle pulse, and it can be masked.

Top module: `bcd_clock_core`

## Requirements
- R1: A bus access hits only when `cs_i` is high and `addr_i[2:0]` is zero; the register index is `addr_i[6:3]`. Indices 0..11 are units then tens for seconds, minutes, hours, day, month and year, and index 12 is the weekday (0 = Sunday). Reads are combinational, and `rdata_o` is 0 with no hit.
- R2: With 24-hour format, each applied second counts 00:00:00 up to 23:59:59 and then wraps to 00:00:00, carrying one day.
- R3: With 12-hour format, hours run 12, 01, ..., 11. Bit 2 of the hours-tens digit is PM, and it toggles when 11 becomes 12. The day advances only on the step from 11 PM to 12 AM.
- R4: The day wraps after the month's last day (30 for months 4, 6, 9 and 11; 31 otherwise; 29 for February when the year count is a multiple of 4, else 28). Month 12 wraps to 01 and carries a year, year 99 wraps to 00, and the weekday goes 6 to 0.
- R5: While index 13 bit 0 (hold) is set, the time digits change only by bus writes. One strobe seen during hold is kept and shown as index 13 bit 1 (busy). It is applied on the second clock edge after the write that clears hold.
- R6: While index 15 bit 1 (stop) is set, second strobes are ignored.
- R7: Writing index 13 with bit 3 set requests a rounding. It is applied on the next edge when hold is clear: seconds become 00, and minutes carry one if seconds were 30 or more. Bit 3 then reads 0.
- R8: Writing index 15 with bit 0 set resets the time to 00:00:00 (12:00:00 AM in 12-hour format), day 01, month 01, year 00, weekday 0. The same write latches the format from bit 2 (1 = 24-hour). Bit 2 written without bit 0 leaves the format as it was. Bit 0 reads as 0.
- R9: Index 14 bits 3:2 choose the periodic source: 00 the 64 Hz strobe, 01 each applied second, 10 each minute carry, 11 each hour carry.
- R10: Each periodic event sets a pending flag that reads as index 13 bit 2. A read of index 13 with `re_i` clears it on that edge. With index 14 bit 1 set, `irq_o` follows the flag.
- R11: With index 14 bit 1 clear, `irq_o` is high for exactly the one cycle after each periodic event.
- R12: With index 14 bit 0 set, `irq_o` stays low, and the pending flag is still kept.
- R13: After `rst_n`, the time is the 24-hour reset time, index 13 and index 14 read 0, index 15 reads 4'b0100, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (side effects only) |
| addr_i | input | 7 | Byte address, index in bits 6:3 |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data |
| sec_tick_i | input | 1 | One-cycle strobe per second |
| tick64_i | input | 1 | One-cycle strobe at 64 Hz |
| irq_o | output | 1 | Periodic interrupt or pulse |

## Verification
A wrong carry decision in the digit chain (month length, leap test, 12-hour PM toggle) shows up as a bad digit on the first read after the strobe that crosses the boundary. A bad hold or pending-second flag shows up as a lost or doubled second two cycles after hold is released. It also shows up at once as a wrong busy bit. A bad periodic-source or pending state shows on `irq_o` in the cycle after the event, or after the clearing read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int DIGIT_W         = 4;
  localparam int IDX_W           = 4;
  localparam int NUM_TIME_DIGITS = 13;

  typedef logic [DIGIT_W-1:0]   digit_t;
  typedef logic [2*DIGIT_W-1:0] bcd2_t;

  typedef enum logic [IDX_W-1:0] {
    IDX_SEC_U  = 4'd0,  IDX_SEC_T  = 4'd1,
    IDX_MIN_U  = 4'd2,  IDX_MIN_T  = 4'd3,
    IDX_HR_U   = 4'd4,  IDX_HR_T   = 4'd5,
    IDX_DAY_U  = 4'd6,  IDX_DAY_T  = 4'd7,
    IDX_MON_U  = 4'd8,  IDX_MON_T  = 4'd9,
    IDX_YR_U   = 4'd10, IDX_YR_T   = 4'd11,
    IDX_WDAY   = 4'd12, IDX_STATUS = 4'd13,
    IDX_PERIOD = 4'd14, IDX_MODE   = 4'd15
  } reg_idx_e;

  typedef enum logic [1:0] {
    SRC_64HZ = 2'b00,
    SRC_SEC  = 2'b01,
    SRC_MIN  = 2'b10,
    SRC_HOUR = 2'b11
  } period_e;

  // add one to a two-digit decimal value (no wrap)
  function automatic bcd2_t bcd_inc(input bcd2_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input bcd2_t yr);
    logic [6:0] bin;
    bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return (bin[1:0] == 2'b00);
  endfunction

  // last valid day of a month, as two decimal digits
  function automatic bcd2_t last_day(input bcd2_t mon, input bcd2_t yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  clr_i,
  input  logic                                  fmt24_i,
  input  logic                                  step_i,
  input  logic                                  round_i,
  input  logic                                  wr_en_i,
  input  logic [IDX_W-1:0]                      wr_idx_i,
  input  digit_t                                wr_data_i,
  output logic [NUM_TIME_DIGITS-1:0][DIGIT_W-1:0] digits_o,
  output logic                                  ev_sec_o,
  output logic                                  ev_min_o,
  output logic                                  ev_hour_o
);

  digit_t digits_q [NUM_TIME_DIGITS];
  digit_t digits_d [NUM_TIME_DIGITS];

  bcd2_t  sec, mnt, hr, day, mon, yr, hv;
  digit_t wday;
  logic   c_min, c_hr, c_day, c_mon, c_yr, pm;
  logic   upd_en;

  assign upd_en = clr_i | step_i | round_i | wr_en_i;

  // next-state: carry chain from seconds up to years
  always_comb begin
    sec  = {digits_q[IDX_SEC_T], digits_q[IDX_SEC_U]};
    mnt  = {digits_q[IDX_MIN_T], digits_q[IDX_MIN_U]};
    hr   = {digits_q[IDX_HR_T],  digits_q[IDX_HR_U]};
    day  = {digits_q[IDX_DAY_T], digits_q[IDX_DAY_U]};
    mon  = {digits_q[IDX_MON_T], digits_q[IDX_MON_U]};
    yr   = {digits_q[IDX_YR_T],  digits_q[IDX_YR_U]};
    wday = digits_q[IDX_WDAY];
    hv   = '0;
    pm   = 1'b0;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;

    if (round_i) begin
      c_min = (sec >= 8'h30);
      sec   = 8'h00;
    end else if (step_i) begin
      if (sec == 8'h59) begin sec = 8'h00; c_min = 1'b1; end
      else              sec = bcd_inc(sec);
    end

    if (c_min) begin
      if (mnt == 8'h59) begin mnt = 8'h00; c_hr = 1'b1; end
      else              mnt = bcd_inc(mnt);
    end

    if (c_hr) begin
      if (fmt24_i) begin
        if (hr == 8'h23) begin hr = 8'h00; c_day = 1'b1; end
        else             hr = bcd_inc(hr);
      end else begin
        pm = hr[6];
        hv = {2'b00, hr[5:0]};
        if (hv == 8'h12)      hv = 8'h01;
        else if (hv == 8'h11) begin
          hv    = 8'h12;
          c_day = pm;
          pm    = ~pm;
        end else              hv = bcd_inc(hv);
        hr = {hr[7], pm, hv[5:0]};
      end
    end

    if (c_day) begin
      wday = (wday >= 4'd6) ? 4'd0 : wday + 4'd1;
      if (day == last_day(mon, yr)) begin day = 8'h01; c_mon = 1'b1; end
      else                          day = bcd_inc(day);
    end

    if (c_mon) begin
      if (mon == 8'h12) begin mon = 8'h01; c_yr = 1'b1; end
      else              mon = bcd_inc(mon);
    end

    if (c_yr) yr = (yr == 8'h99) ? 8'h00 : bcd_inc(yr);

    if (clr_i) begin
      sec = 8'h00; mnt = 8'h00; day = 8'h01; mon = 8'h01; yr = 8'h00; wday = 4'd0;
      hr  = fmt24_i ? 8'h00 : 8'h12;
    end

    digits_d[IDX_SEC_U] = sec[3:0]; digits_d[IDX_SEC_T] = sec[7:4];
    digits_d[IDX_MIN_U] = mnt[3:0]; digits_d[IDX_MIN_T] = mnt[7:4];
    digits_d[IDX_HR_U]  = hr[3:0];  digits_d[IDX_HR_T]  = hr[7:4];
    digits_d[IDX_DAY_U] = day[3:0]; digits_d[IDX_DAY_T] = day[7:4];
    digits_d[IDX_MON_U] = mon[3:0]; digits_d[IDX_MON_T] = mon[7:4];
    digits_d[IDX_YR_U]  = yr[3:0];  digits_d[IDX_YR_T]  = yr[7:4];
    digits_d[IDX_WDAY]  = wday;

    for (int i = 0; i < NUM_TIME_DIGITS; i++) begin
      if (wr_en_i && (wr_idx_i == IDX_W'(i))) digits_d[i] = wr_data_i;
    end
  end

  for (genvar g = 0; g < NUM_TIME_DIGITS; g++) begin : g_digit
    localparam digit_t RST_VAL =
      ((g == int'(IDX_DAY_U)) || (g == int'(IDX_MON_U))) ? 4'd1 : 4'd0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      digits_q[g] <= RST_VAL;
      else if (upd_en) digits_q[g] <= digits_d[g];
    end
    assign digits_o[g] = digits_q[g];
  end

  assign ev_sec_o  = step_i & ~clr_i;
  assign ev_min_o  = c_min & ~clr_i;
  assign ev_hour_o = c_hr & ~clr_i;

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic
  import rtc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick64_i,
  input  logic    ev_sec_i,
  input  logic    ev_min_i,
  input  logic    ev_hour_i,
  input  period_e src_i,
  input  logic    level_i,
  input  logic    mask_i,
  input  logic    ack_i,
  output logic    pend_o,
  output logic    irq_o
);
  logic event_now;
  logic pend_q, pend_d;
  logic pulse_q, pulse_d;

  always_comb begin
    case (src_i)
      SRC_64HZ: event_now = tick64_i;
      SRC_SEC:  event_now = ev_sec_i;
      SRC_MIN:  event_now = ev_min_i;
      SRC_HOUR: event_now = ev_hour_i;
      default:  event_now = 1'b0;
    endcase
    pend_d  = event_now | (pend_q & ~ack_i);
    pulse_d = event_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = ~mask_i & (level_i ? pend_q : pulse_q);
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int REG_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        wdata_i,
  output logic [3:0]        rdata_o,
  input  logic              sec_tick_i,
  input  logic              tick64_i,
  output logic              irq_o
);

  localparam int LAST_TIME_IDX = NUM_TIME_DIGITS - 1;

  logic rst_ns;
  logic [IDX_W-1:0] idx;
  logic bus_hit, bus_wr, bus_rd, wr_time, wr_status, wr_period, wr_mode;
  logic clr_time, adj_set, ack_rd, do_round, do_step;

  logic hold_q, hold_d, adj_q, adj_d, tickp_q, tickp_d;
  logic stop_q, test_q, mode24_q;
  logic mask_q, level_q;
  period_e src_q;
  logic irq_pend;
  logic ev_sec, ev_min, ev_hour;
  logic [NUM_TIME_DIGITS-1:0][DIGIT_W-1:0] time_digits;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_ns)
  );

  // bus decode
  assign bus_hit   = cs_i && (addr_i[REG_SHIFT-1:0] == '0);
  assign idx       = addr_i[REG_SHIFT +: IDX_W];
  assign bus_wr    = bus_hit && we_i;
  assign bus_rd    = bus_hit && re_i;
  assign wr_time   = bus_wr && (idx <= IDX_W'(LAST_TIME_IDX));
  assign wr_status = bus_wr && (idx == IDX_STATUS);
  assign wr_period = bus_wr && (idx == IDX_PERIOD);
  assign wr_mode   = bus_wr && (idx == IDX_MODE);
  assign clr_time  = wr_mode && wdata_i[0];
  assign adj_set   = wr_status && wdata_i[3];
  assign ack_rd    = bus_rd && (idx == IDX_STATUS);

  // sequencing of held seconds and rounding
  assign do_round = adj_q && !hold_q && !clr_time;
  assign do_step  = !clr_time && !hold_q && !stop_q && !do_round &&
                    (sec_tick_i || tickp_q);

  always_comb begin
    hold_d = wr_status ? wdata_i[0] : hold_q;

    if (clr_time)      adj_d = 1'b0;
    else if (adj_set)  adj_d = 1'b1;
    else if (do_round) adj_d = 1'b0;
    else               adj_d = adj_q;

    if (clr_time)      tickp_d = 1'b0;
    else if (hold_q)   tickp_d = tickp_q | (sec_tick_i & ~stop_q);
    else if (do_round) tickp_d = 1'b0;
    else if (stop_q)   tickp_d = tickp_q;
    else               tickp_d = tickp_q & sec_tick_i;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hold_q  <= 1'b0;
      adj_q   <= 1'b0;
      tickp_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      adj_q   <= adj_d;
      tickp_q <= tickp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      stop_q   <= 1'b0;
      test_q   <= 1'b0;
      mode24_q <= 1'b1;
    end else if (wr_mode) begin
      stop_q <= wdata_i[1];
      test_q <= wdata_i[3];
      if (wdata_i[0]) mode24_q <= wdata_i[2];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mask_q  <= 1'b0;
      level_q <= 1'b0;
      src_q   <= SRC_64HZ;
    end else if (wr_period) begin
      mask_q  <= wdata_i[0];
      level_q <= wdata_i[1];
      src_q   <= period_e'(wdata_i[3:2]);
    end
  end

  rtc_timekeeper u_time (
    .clk       (clk),
    .rst_n     (rst_ns),
    .clr_i     (clr_time),
    .fmt24_i   (clr_time ? wdata_i[2] : mode24_q),
    .step_i    (do_step),
    .round_i   (do_round),
    .wr_en_i   (wr_time),
    .wr_idx_i  (idx),
    .wr_data_i (wdata_i),
    .digits_o  (time_digits),
    .ev_sec_o  (ev_sec),
    .ev_min_o  (ev_min),
    .ev_hour_o (ev_hour)
  );

  rtc_periodic u_per (
    .clk       (clk),
    .rst_n     (rst_ns),
    .tick64_i  (tick64_i),
    .ev_sec_i  (ev_sec),
    .ev_min_i  (ev_min),
    .ev_hour_i (ev_hour),
    .src_i     (src_q),
    .level_i   (level_q),
    .mask_i    (mask_q),
    .ack_i     (ack_rd),
    .pend_o    (irq_pend),
    .irq_o     (irq_o)
  );

  // read mux
  always_comb begin
    rdata_o = '0;
    if (bus_hit) begin
      if (idx <= IDX_W'(LAST_TIME_IDX)) rdata_o = time_digits[idx];
      else begin
        case (idx)
          IDX_STATUS: rdata_o = {adj_q, irq_pend, tickp_q, hold_q};
          IDX_PERIOD: rdata_o = {src_q, level_q, mask_q};
          IDX_MODE:   rdata_o = {test_q, mode24_q, stop_q, 1'b0};
          default:    rdata_o = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
(
  input logic clk,
  input logic rst_ns,
  input logic hold_q,
  input logic stop_q,
  input logic tickp_q,
  input logic adj_q,
  input logic adj_set,
  input logic mask_q,
  input logic mode24_q,
  input logic irq_pend,
  input logic irq_o,
  input logic sec_tick_i,
  input logic bus_wr,
  input logic clr_time,
  input logic ack_rd,
  input logic [NUM_TIME_DIGITS-1:0][DIGIT_W-1:0] time_digits
);

  // R5
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (hold_q && !bus_wr) |=> $stable(time_digits));

  // R5
  held_tick_kept_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (hold_q && sec_tick_i && !stop_q && !clr_time) |=> tickp_q);

  // R6
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (stop_q && !bus_wr && !adj_q) |=> $stable(time_digits));

  // R7
  round_done_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (adj_q && !hold_q && !adj_set) |=> !adj_q);

  // R8
  fmt_latch_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !clr_time |=> $stable(mode24_q));

  // R12
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    mask_q |-> !irq_o);

  // R10
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (irq_pend && !ack_rd) |=> irq_pend);

endmodule

bind bcd_clock_core rtc_chk u_chk (
  .clk         (clk),
  .rst_ns      (rst_ns),
  .hold_q      (hold_q),
  .stop_q      (stop_q),
  .tickp_q     (tickp_q),
  .adj_q       (adj_q),
  .adj_set     (adj_set),
  .mask_q      (mask_q),
  .mode24_q    (mode24_q),
  .irq_pend    (irq_pend),
  .irq_o       (irq_o),
  .sec_tick_i  (sec_tick_i),
  .bus_wr      (bus_wr),
  .clr_time    (clr_time),
  .ack_rd      (ack_rd),
  .time_digits (time_digits)
);

// File: tb/tb_bcd_clock_core.sv
`timescale 1ns/1ps
module tb_bcd_clock_core;

  logic       clk = 1'b0;
  logic       rst_n, cs, we, re, sec_tick, tick64;
  logic [6:0] addr;
  logic [3:0] wdata, rdata;
  logic       irq;

  always #10 clk = ~clk;

  bcd_clock_core dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sec_tick_i(sec_tick), .tick64_i(tick64), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;

  // reference time model
  int  ms, mm, mh, md, mmo, my, mw;
  bit  m24;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [3:0] exp_digit(input int i);
    int h12;
    h12 = (mh % 12 == 0) ? 12 : mh % 12;
    case (i)
      0: return 4'(ms % 10);   1: return 4'(ms / 10);
      2: return 4'(mm % 10);   3: return 4'(mm / 10);
      4: return m24 ? 4'(mh % 10) : 4'(h12 % 10);
      5: return m24 ? 4'(mh / 10) : 4'((mh >= 12 ? 4 : 0) + h12 / 10);
      6: return 4'(md % 10);   7: return 4'(md / 10);
      8: return 4'(mmo % 10);  9: return 4'(mmo / 10);
      10: return 4'(my % 10);  11: return 4'(my / 10);
      default: return 4'(mw);
    endcase
  endfunction

  task automatic model_min_carry();
    mm++;
    if (mm == 60) begin
      mm = 0; mh++;
      if (mh == 24) begin
        mh = 0; md++; mw = (mw + 1) % 7;
        if (md > dim(mmo, my)) begin
          md = 1; mmo++;
          if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
        end
      end
    end
  endtask

  task automatic model_step();
    ms++;
    if (ms == 60) begin ms = 0; model_min_carry(); end
  endtask

  task automatic peek(input int idx, output logic [3:0] v);
    @(negedge clk);
    cs = 1; we = 0; re = 0; addr = 7'(idx << 3);
    #1 v = rdata;
    cs = 0;
  endtask

  task automatic poke(input int idx, input logic [3:0] val);
    @(negedge clk);
    cs = 1; we = 1; addr = 7'(idx << 3); wdata = val;
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic rd_ack(output logic [3:0] v);
    @(negedge clk);
    cs = 1; re = 1; addr = 7'(13 << 3);
    #1 v = rdata;
    @(negedge clk);
    cs = 0; re = 0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic set_fmt(input bit is24);
    poke(15, is24 ? 4'b0101 : 4'b0001);
    m24 = is24; ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 0;
  endtask

  task automatic load(input int s, input int mi, input int h, input int d,
                      input int mo, input int y, input int w);
    ms = s; mm = mi; mh = h; md = d; mmo = mo; my = y; mw = w;
    poke(13, 4'b0001);
    for (int i = 0; i < 13; i++) poke(i, exp_digit(i));
    poke(13, 4'b0000);
  endtask

  task automatic check_time(input string req);
    logic [3:0] v;
    for (int i = 0; i < 13; i++) begin
      peek(i, v);
      check(req, v, exp_digit(i));
    end
  endtask

  task automatic irq_now(input string req, input bit exp);
    #1 check(req, irq, exp);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog R13 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] v;
    int seed, n, dd;
    rst_n = 0; cs = 0; we = 0; re = 0; addr = '0; wdata = '0;
    sec_tick = 0; tick64 = 0;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R13 reset state
    m24 = 1; ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 0;
    irq_now("R13 irq", 1'b0);
    check_time("R13 time");
    peek(13, v); check("R13 status", v, 0);
    peek(14, v); check("R13 period", v, 0);
    peek(15, v); check("R13 mode", v, 4'b0100);

    // R1 decode
    @(negedge clk); cs = 0; addr = 7'(6 << 3); #1 check("R1 no select", rdata, 0);
    @(negedge clk); cs = 1; addr = 7'h31;      #1 check("R1 misaligned read", rdata, 0);
    cs = 0;
    @(negedge clk); cs = 1; we = 1; addr = 7'h01; wdata = 4'd5;
    @(negedge clk); cs = 0; we = 0;
    check_time("R1 misaligned write ignored");

    // R2 24-hour wrap
    load(59, 59, 23, 15, 6, 24, 3); tick(); model_step(); check_time("R2");
    // R4 calendar
    load(59, 59, 23, 31, 12, 99, 6); tick(); model_step(); check_time("R4 year wrap");
    load(59, 59, 23, 28, 2, 24, 2);  tick(); model_step(); check_time("R4 leap feb28");
    load(59, 59, 23, 29, 2, 24, 2);  tick(); model_step(); check_time("R4 leap feb29");
    load(59, 59, 23, 28, 2, 23, 2);  tick(); model_step(); check_time("R4 common feb");
    load(59, 59, 23, 30, 4, 10, 1);  tick(); model_step(); check_time("R4 30-day month");

    // R8 format latch
    set_fmt(0);
    check_time("R8 reset 12h");
    peek(15, v); check("R8 fmt 12h", v, 4'b0000);
    poke(15, 4'b0100);
    peek(15, v); check("R8 fmt without reset", v, 4'b0000);

    // R3 12-hour sequence
    load(59, 59, 11, 10, 3, 20, 1); tick(); model_step(); check_time("R3 11AM-12PM");
    load(59, 59, 23, 10, 3, 20, 1); tick(); model_step(); check_time("R3 11PM-12AM");
    load(59, 59, 0, 10, 3, 20, 1);  tick(); model_step(); check_time("R3 12AM-1AM");
    load(59, 59, 12, 10, 3, 20, 1); tick(); model_step(); check_time("R3 12PM-1PM");

    set_fmt(1);
    // R5 hold with a second arriving
    load(10, 20, 5, 6, 7, 8, 2);
    poke(13, 4'b0001);
    tick();
    peek(13, v); check("R5 busy", v, 4'b0011);
    peek(0, v);  check("R5 frozen", v, 0);
    poke(13, 4'b0000);
    @(negedge clk);
    model_step();
    check_time("R5 applied after release");
    peek(13, v); check("R5 busy clear", v, 0);

    // R6 stop
    poke(15, 4'b0010);
    peek(15, v); check("R6 mode read", v, 4'b0110);
    repeat (3) tick();
    check_time("R6 stopped");
    poke(15, 4'b0000);
    tick(); model_step(); check_time("R6 restarted");

    // R7 rounding
    load(29, 10, 5, 6, 7, 8, 2);
    poke(13, 4'b1000);
    ms = 0;
    check_time("R7 round down");
    peek(13, v); check("R7 self clear", v, 0);
    load(45, 59, 23, 31, 12, 99, 6);
    poke(13, 4'b1000);
    ms = 0; model_min_carry();
    check_time("R7 round up");

    // R10 level interrupt on each second
    rd_ack(v);
    poke(14, 4'b0110);
    irq_now("R10 idle", 1'b0);
    tick(); model_step();
    irq_now("R10 level set", 1'b1);
    peek(13, v); check("R10 pending bit", v[2], 1);
    rd_ack(v);
    irq_now("R10 cleared by read", 1'b0);

    // R9 minute and hour sources
    poke(14, 4'b1010);
    load(30, 0, 1, 1, 1, 1, 1); tick(); irq_now("R9 minute no event", 1'b0);
    load(59, 0, 1, 1, 1, 1, 1); tick(); irq_now("R9 minute event", 1'b1);
    rd_ack(v);
    poke(14, 4'b1110);
    load(59, 58, 1, 1, 1, 1, 1); tick(); irq_now("R9 hour no event", 1'b0);
    load(59, 59, 1, 1, 1, 1, 1); tick(); irq_now("R9 hour event", 1'b1);
    rd_ack(v);

    // R11 pulses, R9 64 Hz source
    poke(14, 4'b0000);
    @(negedge clk); tick64 = 1;
    @(negedge clk); tick64 = 0;
    irq_now("R11 pulse 64Hz high", 1'b1);
    @(negedge clk); irq_now("R11 pulse 64Hz low", 1'b0);
    tick(); irq_now("R9 64Hz ignores second", 1'b0);
    poke(14, 4'b0100);
    tick(); irq_now("R11 pulse 1Hz high", 1'b1);
    @(negedge clk); irq_now("R11 pulse 1Hz low", 1'b0);

    // R12 mask
    rd_ack(v);
    poke(14, 4'b0111);
    tick(); irq_now("R12 masked", 1'b0);
    peek(13, v); check("R12 pending kept", v[2], 1);
    poke(14, 4'b0110);
    irq_now("R12 unmasked", 1'b1);
    rd_ack(v);

    // random runs with mixed formats
    for (int it = 0; it < 8; it++) begin
      int s, mi, h, mo, y;
      set_fmt(it % 2 == 0);
      y  = $urandom % 100;
      mo = 1 + $urandom % 12;
      dd = ($urandom % 2) ? dim(mo, y) : 1 + $urandom % dim(mo, y);
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      s  = 50 + $urandom % 10;
      load(s, mi, h, dd, mo, y, $urandom % 7);
      n = 1 + $urandom % 150;
      for (int k = 0; k < n; k++) begin
        if ($urandom % 8 == 0) begin
          poke(13, 4'b0001); tick(); poke(13, 4'b0000); @(negedge clk);
        end else tick();
        model_step();
      end
      check_time(m24 ? "R4 random 24h" : "R3 random 12h");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule